// File: doc/BRIEF.md
# Deferred DAC Update Writer

This block holds a batch of pending DAC updates and sends them over an SPI bus that an ADC also uses. The host fills a small local store with a count byte and then pairs of (value, channel) bytes. Nothing goes to the DAC when the store is written. On each frame tick the block checks the ADC's conversion-start line. If that line is low, the ADC is quiet and the block sends every stored update, one SPI transaction per update. If the line is high, the block skips that tick. The ADC therefore always gets the bus first.

Each update is a 16-bit frame inside an active-low chip select. The first byte holds the channel number in its upper nibble and the upper half of the value in its lower nibble. The second byte holds the lower half of the value in its upper nibble and zeros below it. The stored batch stays in place and is sent again on every allowed tick until the host replaces it. A one-cycle done pulse marks the end of each batch.

Top module: `dac_defer_writer`

## Requirements
- R1: After reset `dac_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0 and `batch_done` is 0. The stored count is zero, so a frame tick before the first load sends nothing.
- R2: A host write with `host_first`=1 starts a load, and its byte is the update count. The following writes alternate value byte, then channel byte, one pair per update. The new batch becomes sendable only when its last channel byte is written. Until then the stored count is zero.
- R3: A load with count 0 leaves nothing to send, so later frame ticks produce no SPI activity.
- R4: A count above `MAX_UPD` is clamped to `MAX_UPD`. Only the first `MAX_UPD` pairs are stored, and bytes after the last stored pair are ignored.
- R5: A frame tick starts a batch only when `adc_start` is 0 and the block is idle. A tick with `adc_start`=1, or a tick during a batch, has no effect.
- R6: Each update is one transaction: `dac_cs_n` falls, exactly 16 rising `spi_sclk` edges occur, then `dac_cs_n` rises. `spi_sclk` toggles only while `dac_cs_n` is low. `dac_cs_n` stays high for at least one clock between frames.
- R7: The first byte of a frame is {channel[3:0], value[7:4]}.
- R8: The second byte of a frame is {value[3:0], 4'b0000}.
- R9: Bits go out MSB first. `spi_sclk` idles low, and `spi_mosi` changes only while `spi_sclk` is low, so the DAC samples it on the rising edge.
- R10: `batch_done` is a one-cycle pulse, raised in the cycle `dac_cs_n` rises after the last frame of a batch.
- R11: A load that starts during a batch never cuts a frame short. The frame in progress completes, the batch then ends with `batch_done`, and the next allowed tick sends the new contents.
- R12: A stored batch is kept after it is sent. Each later allowed tick sends it again, in buffer order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_first | input | 1 | Marks the write as the count byte that starts a load |
| host_byte | input | 8 | Host data byte (count, value or channel) |
| frame_tick | input | 1 | One-cycle request to send the stored batch |
| adc_start | input | 1 | ADC conversion running when 1 |
| dac_cs_n | output | 1 | Active-low DAC chip select |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to the DAC |
| batch_done | output | 1 | One-cycle pulse after the last frame of a batch |

## Verification
The bound checker watches the bus-level rules on every cycle. These are: clock pulses only inside chip select, exactly sixteen rising edges per frame, data held steady while the clock is high, the done pulse being one cycle wide and aligned with chip select rising, and no transaction starting when a tick arrives while the ADC is converting. The content of the frames can only be shown by the bench's scenarios. That covers the nibble packing, the batch order, clamping, loads that are incomplete or that replace a batch mid-send, and a batch being sent again on later ticks. The bench decodes the serial stream and compares it with words built from the loaded bytes.

// File: rtl/dacq_pkg.sv
// Package: shared types and frame-formatting helpers for the deferred DAC writer.
// Assumes the DAC frame is two bytes: channel/high nibble, then low nibble/zero pad.
package dacq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HI   = 2'd1,
        SEQ_LO   = 2'd2,
        SEQ_GAP  = 2'd3
    } seq_state_t;

    // First frame byte: channel in the upper nibble, value bits 7:4 below.
    function automatic logic [7:0] frame_hi(input logic [7:0] val, input logic [3:0] chan);
        return {chan, val[7:4]};
    endfunction

    // Second frame byte: value bits 3:0 on top, zero padding below.
    function automatic logic [7:0] frame_lo(input logic [3:0] val_lo);
        return {val_lo, 4'h0};
    endfunction

endpackage

// File: rtl/dacq_buffer.sv
// Module: update store. Accepts a count byte followed by (value, channel) pairs
// and publishes the count only once every pair of the load is present.
// Assumes MAX_UPD <= 255 and that the host never interleaves two loads.
module dacq_buffer #(
    parameter int MAX_UPD = 8,
    parameter int CNT_W   = $clog2(MAX_UPD + 1),
    parameter int IDX_W   = (MAX_UPD > 1) ? $clog2(MAX_UPD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_first,
    input  logic [7:0]       host_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_val,
    output logic [3:0]       rd_chan,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             load_start
);

    logic [7:0]       val_mem  [MAX_UPD];
    logic [3:0]       chan_mem [MAX_UPD];
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] clamped;
    logic [IDX_W-1:0] wptr;
    logic             want_chan;
    logic             loading;

    assign load_start = host_wr && host_first;

    // Clamp the requested count to the storage depth.
    always_comb begin
        if (host_byte > 8'(MAX_UPD)) clamped = CNT_W'(MAX_UPD);
        else                         clamped = host_byte[CNT_W-1:0];
    end

    // Load control: restart on a count byte, fill pairs, publish count at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt  <= '0;
            target    <= '0;
            wptr      <= '0;
            want_chan <= 1'b0;
            loading   <= 1'b0;
        end else if (load_start) begin
            pend_cnt  <= '0;
            target    <= clamped;
            wptr      <= '0;
            want_chan <= 1'b0;
            loading   <= (clamped != '0);
        end else if (host_wr && loading) begin
            if (!want_chan) begin
                want_chan <= 1'b1;
            end else begin
                want_chan <= 1'b0;
                if (CNT_W'(wptr) + CNT_W'(1) == target) begin
                    pend_cnt <= target;
                    loading  <= 1'b0;
                end else begin
                    wptr <= wptr + IDX_W'(1);
                end
            end
        end
    end

    // Storage writes: value byte then channel byte at the current slot.
    always_ff @(posedge clk) begin
        if (host_wr && !host_first && loading) begin
            if (!want_chan) val_mem[wptr]  <= host_byte;
            else            chan_mem[wptr] <= host_byte[3:0];
        end
    end

    assign rd_val  = val_mem[rd_idx];
    assign rd_chan = chan_mem[rd_idx];

endmodule

// File: rtl/dacq_spi_byte.sv
// Module: byte-level SPI shifter. Sends one byte MSB first with the clock idling
// low; data moves on the falling edge. Each half period lasts HALF clk cycles.
// Assumes go is pulsed only while the shifter is idle.
module dacq_spi_byte #(
    parameter int HALF  = 2,
    parameter int DIV_W = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] din,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done
);

    logic             active;
    logic             phase;
    logic [7:0]       sh;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] divc;

    // Half-period timing, bit shifting and end-of-byte pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase     <= 1'b0;
            sh        <= '0;
            bitn      <= '0;
            divc      <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go) begin
                sh     <= din;
                bitn   <= '0;
                phase  <= 1'b0;
                divc   <= '0;
                active <= 1'b1;
            end else if (active) begin
                if (divc == DIV_W'(HALF - 1)) begin
                    divc <= '0;
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    divc <= divc + DIV_W'(1);
                end
            end
        end
    end

    assign sclk = active & phase;
    assign mosi = active & sh[7];

endmodule

// File: rtl/dacq_sequencer.sv
// Module: batch sequencer. On an allowed tick it walks the stored updates,
// framing each as two bytes under chip select, and pulses done at the end.
// Assumes the buffer count is stable except when a new load starts.
module dacq_sequencer
    import dacq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             adc_start,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic             load_start,
    input  logic [7:0]       rd_val,
    input  logic [3:0]       rd_chan,
    input  logic             byte_done,
    output logic [IDX_W-1:0] rd_idx,
    output logic             go,
    output logic [7:0]       din,
    output logic             cs_n,
    output logic             done,
    output logic             busy
);

    seq_state_t state;
    logic [7:0] lat_val;
    logic       abort;
    logic       last_frame;

    assign rd_idx     = (state == SEQ_IDLE) ? '0 : idx_q;
    assign busy       = (state != SEQ_IDLE);
    assign last_frame = abort || load_start || (CNT_W'(idx_q) + CNT_W'(1) == pend_cnt);

    logic [IDX_W-1:0] idx_q;

    // Batch state machine: gate on ADC idle, issue bytes, close frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            idx_q   <= '0;
            lat_val <= '0;
            abort   <= 1'b0;
            go      <= 1'b0;
            din     <= '0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            if (load_start && state != SEQ_IDLE) abort <= 1'b1;
            case (state)
                SEQ_IDLE: begin
                    if (frame_tick && !adc_start && pend_cnt != '0) begin
                        idx_q   <= '0;
                        abort   <= load_start;
                        lat_val <= rd_val;
                        din     <= frame_hi(rd_val, rd_chan);
                        go      <= 1'b1;
                        cs_n    <= 1'b0;
                        state   <= SEQ_HI;
                    end
                end
                SEQ_HI: begin
                    if (byte_done) begin
                        din   <= frame_lo(lat_val[3:0]);
                        go    <= 1'b1;
                        state <= SEQ_LO;
                    end
                end
                SEQ_LO: begin
                    if (byte_done) begin
                        cs_n <= 1'b1;
                        if (last_frame) begin
                            done  <= 1'b1;
                            idx_q <= '0;
                            state <= SEQ_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            state <= SEQ_GAP;
                        end
                    end
                end
                SEQ_GAP: begin
                    lat_val <= rd_val;
                    din     <= frame_hi(rd_val, rd_chan);
                    go      <= 1'b1;
                    cs_n    <= 1'b0;
                    state   <= SEQ_HI;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dac_defer_writer.sv
// Module: top of the deferred DAC writer. Joins the update store, the batch
// sequencer and the SPI byte shifter. Assumes adc_start is synchronous to clk.
module dac_defer_writer #(
    parameter int MAX_UPD   = 8,
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_first,
    input  logic [7:0] host_byte,
    input  logic       frame_tick,
    input  logic       adc_start,
    output logic       dac_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       batch_done
);

    localparam int CNT_W = $clog2(MAX_UPD + 1);
    localparam int IDX_W = (MAX_UPD > 1) ? $clog2(MAX_UPD) : 1;

    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_val;
    logic [3:0]       rd_chan;
    logic [CNT_W-1:0] pend_cnt;
    logic             load_start;
    logic             sh_go;
    logic [7:0]       sh_din;
    logic             sh_done;
    logic             seq_busy;

    dacq_buffer #(
        .MAX_UPD (MAX_UPD),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_first (host_first),
        .host_byte  (host_byte),
        .rd_idx     (rd_idx),
        .rd_val     (rd_val),
        .rd_chan    (rd_chan),
        .pend_cnt   (pend_cnt),
        .load_start (load_start)
    );

    dacq_sequencer #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .adc_start  (adc_start),
        .pend_cnt   (pend_cnt),
        .load_start (load_start),
        .rd_val     (rd_val),
        .rd_chan    (rd_chan),
        .byte_done  (sh_done),
        .rd_idx     (rd_idx),
        .go         (sh_go),
        .din        (sh_din),
        .cs_n       (dac_cs_n),
        .done       (batch_done),
        .busy       (seq_busy)
    );

    dacq_spi_byte #(
        .HALF (SCLK_HALF)
    ) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (sh_go),
        .din       (sh_din),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_done (sh_done)
    );

endmodule

// File: rtl/dacq_checker.sv
// Module: protocol checker bound to the top. Watches the SPI framing, the
// done pulse and the ADC gate on every cycle.
module dacq_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_tick,
    input logic adc_start,
    input logic seq_busy,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic done
);

    logic       sclk_d;
    logic [4:0] rise_cnt;

    // Count rising clock edges inside the current chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)                 rise_cnt <= '0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 5'd1;
        end
    end

    assert_sclk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_sixteen_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 5'd16));

    assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_done_at_cs_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_adc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && adc_start && !seq_busy) |=> cs_n);

endmodule

bind dac_defer_writer dacq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .adc_start  (adc_start),
    .seq_busy   (seq_busy),
    .cs_n       (dac_cs_n),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .done       (batch_done)
);

// File: tb/dac_defer_writer_tb.sv
module dac_defer_writer_tb;

    localparam int MAXU = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_first = 1'b0;
    logic [7:0] host_byte = '0;
    logic       frame_tick = 1'b0;
    logic       adc_start = 1'b0;
    logic       dac_cs_n, spi_sclk, spi_mosi, batch_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dac_defer_writer #(.MAX_UPD(MAXU), .SCLK_HALF(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_first(host_first),
        .host_byte(host_byte), .frame_tick(frame_tick), .adc_start(adc_start),
        .dac_cs_n(dac_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .batch_done(batch_done)
    );

    // Serial stream monitor.
    logic [15:0] shreg = '0;
    int          bitn = 0;
    bit          frame_open = 0;
    logic [15:0] frames [0:31];
    int          lens   [0:31];
    int          nframes = 0;
    int          ndone = 0;
    int          mosi_moves_high = 0;
    logic        prev_sclk = 0, prev_mosi = 0;

    always @(negedge dac_cs_n) begin frame_open = 1; bitn = 0; end
    always @(posedge spi_sclk) if (!dac_cs_n) begin
        shreg = {shreg[14:0], spi_mosi};
        bitn++;
    end
    always @(posedge dac_cs_n) if (frame_open) begin
        if (nframes < 32) begin frames[nframes] = shreg; lens[nframes] = bitn; end
        nframes++;
        frame_open = 0;
    end
    always @(negedge clk) begin
        if (batch_done) ndone++;
        if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) mosi_moves_high++;
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
    end

    logic [7:0] vals  [0:15];
    logic [7:0] chans [0:15];

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input bit f, input logic [7:0] b);
        host_wr = 1'b1; host_first = f; host_byte = b;
        @(negedge clk);
        host_wr = 1'b0; host_first = 1'b0;
    endtask

    task automatic load(input int n);
        put(1'b1, 8'(n));
        for (int i = 0; i < n; i++) begin
            put(1'b0, vals[i]);
            put(1'b0, chans[i]);
        end
    endtask

    task automatic tick(input bit s);
        adc_start = s; frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0; adc_start = 1'b0;
    endtask

    task automatic clear_log();
        nframes = 0; ndone = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] word(input int i);
        return {chans[i][3:0], vals[i], 4'h0};
    endfunction

    task automatic check_frames(input string req, input int n);
        chk({req, " frame count"}, nframes, n);
        for (int i = 0; i < n && i < nframes; i++) begin
            chk({req, " frame word"}, int'(frames[i]), int'(word(i)));
            chk("R6 bits per frame", lens[i], 16);
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", int'(dac_cs_n), 1);
        chk("R1 sclk", int'(spi_sclk), 0);
        chk("R1 mosi", int'(spi_mosi), 0);
        chk("R1 done", int'(batch_done), 0);
        clear_log(); tick(1'b0); idle(100);
        chk("R1 nothing before first load", nframes, 0);
    endtask

    task automatic t_basic();
        vals[0] = 8'hA5; chans[0] = 8'h03;
        vals[1] = 8'h3C; chans[1] = 8'h0E;
        vals[2] = 8'hF0; chans[2] = 8'h07;
        load(3); clear_log(); tick(1'b0); idle(400);
        check_frames("R7 R8 R2 basic batch", 3);
        chk("R10 one done per batch", ndone, 1);
        clear_log(); tick(1'b0); idle(400);
        check_frames("R12 resend", 3);
        chk("R12 done on resend", ndone, 1);
    endtask

    task automatic t_adc_gate();
        clear_log(); tick(1'b1); idle(300);
        chk("R5 adc busy skips tick", nframes, 0);
        chk("R5 no done when skipped", ndone, 0);
        chk("R5 cs held high", int'(dac_cs_n), 1);
    endtask

    task automatic t_zero();
        load(0); clear_log(); tick(1'b0); idle(300);
        chk("R3 zero count sends nothing", nframes, 0);
        chk("R3 zero count no done", ndone, 0);
    endtask

    task automatic t_clamp();
        for (int i = 0; i < 10; i++) begin
            vals[i] = 8'(8'h11 * i + 8'h07); chans[i] = 8'(i);
        end
        load(10); clear_log(); tick(1'b0); idle(900);
        check_frames("R4 clamped batch", MAXU);
        chk("R4 done after clamp", ndone, 1);
    endtask

    task automatic t_partial();
        vals[0] = 8'h5A; chans[0] = 8'h09;
        vals[1] = 8'hC3; chans[1] = 8'h02;
        put(1'b1, 8'd2); put(1'b0, vals[0]); put(1'b0, chans[0]); put(1'b0, vals[1]);
        clear_log(); tick(1'b0); idle(300);
        chk("R2 incomplete load sends nothing", nframes, 0);
        put(1'b0, chans[1]);
        clear_log(); tick(1'b0); idle(400);
        check_frames("R2 completed load", 2);
    endtask

    task automatic t_reload();
        logic [15:0] first_old;
        vals[0] = 8'h81; chans[0] = 8'h04;
        vals[1] = 8'h92; chans[1] = 8'h05;
        vals[2] = 8'hA3; chans[2] = 8'h06;
        vals[3] = 8'hB4; chans[3] = 8'h07;
        load(4); first_old = word(0);
        clear_log(); tick(1'b0); idle(20);
        vals[0] = 8'h1E; chans[0] = 8'h0B;
        vals[1] = 8'h2D; chans[1] = 8'h0C;
        load(2); idle(400);
        chk("R11 batch ends after current frame", nframes, 1);
        chk("R11 current frame intact", int'(frames[0]), int'(first_old));
        chk("R11 done after cut batch", ndone, 1);
        clear_log(); tick(1'b0); idle(400);
        check_frames("R11 new contents", 2);
    endtask

    task automatic t_busy_tick();
        vals[0] = 8'h66; chans[0] = 8'h01;
        vals[1] = 8'h99; chans[1] = 8'h0F;
        load(2); clear_log(); tick(1'b0); idle(30); tick(1'b0); idle(400);
        check_frames("R5 tick while busy ignored", 2);
        chk("R5 single done", ndone, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_adc_gate();
        t_zero();
        t_clamp();
        t_partial();
        t_reload();
        t_busy_tick();
        chk("R9 mosi steady while sclk high", mosi_moves_high, 0);
        chk("R6 cs idle high at end", int'(dac_cs_n), 1);
        summary();
        $finish;
    end

endmodule